// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Transceiver

This block sends and receives bytes over a two-wire asynchronous serial link: one start bit at low level, eight data bits with the least significant bit first, and one stop bit at high level. Bytes to send are queued in a 16-entry transmit FIFO. Received bytes go into a 16-entry receive FIFO. Each received byte carries a framing-error flag that travels with it.

Bit timing comes from an oversampling tick, at 16 or 8 ticks per bit. The tick is taken either from an internal divider of the system clock or from rising edges on an external serial-clock input. When the internal divider is in use, the block can drive the oversampling clock out on the serial-clock pin. That pin is split into input, output and output-enable ports, so the pad stays outside the block. Transmit and receive each have their own enable. Switching the transmitter off drops only the frame in flight, and any bytes still in the FIFO stay queued. Queued bytes are discarded only by the transmit-FIFO clear.

Top module: `serial_fifo_xcvr`

## Requirements
- R1: The idle line is high (mark). Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. A byte received from a valid frame appears at `rx_data` with `rx_ferr` = 0.
- R2: Every bit lasts 16 ticks when `os8` = 0 and 8 ticks when `os8` = 1. With the internal source, one tick is generated every `baud_div`+1 clock cycles.
- R3: When `ck_sel[1]` = 1, one tick is taken from each rising edge of `sck_i`, and the internal divider has no effect on bit timing.
- R4: `sck_oe` is 1 only when `ck_sel` = 2'b01. In that case `sck_o` makes exactly one rising edge per internal tick period. When `sck_oe` is 0, `sck_o` is 0.
- R5: The transmit FIFO holds 16 bytes and `tx_full` is then 1. A write while the FIFO is full is dropped, and that byte is never transmitted.
- R6: While `tx_en` is 0, `txd` is high from the next cycle on and the frame in flight is abandoned. Bytes still queued remain, and they are sent once `tx_en` returns to 1.
- R7: A one-cycle pulse on `tx_fifo_clr` empties the transmit FIFO. The discarded bytes are never sent.
- R8: `tx_end` is 1 when the transmit FIFO is empty and no frame is being shifted out. That includes the stop bit of the last byte. Otherwise `tx_end` is 0. A write to the FIFO clears `tx_end` within two cycles.
- R9: A start bit is accepted only if the line is still low at tick 8 of 16 (or tick 4 of 8) after the falling edge. A shorter low pulse is ignored and no byte is stored.
- R10: A frame whose stop-bit sample is low is still stored, with `rx_ferr` = 1 alongside its data.
- R11: `rx_rd` pops the receive FIFO, and the popped entry appears on `rx_data`/`rx_ferr` one cycle later. A pop of an empty FIFO leaves both outputs unchanged.
- R12: While `rx_en` is 0, line activity stores nothing. Bytes already held in the receive FIFO are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ck_sel | input | 2 | Tick source: 00 internal, 01 internal with clock output, 1x external |
| os8 | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| baud_div | input | 16 | Internal divider: tick every baud_div+1 cycles (use 1 or more) |
| sck_i | input | 1 | External oversampling clock from the pin |
| sck_o | output | 1 | Oversampling clock driven to the pin |
| sck_oe | output | 1 | Output enable for the serial-clock pin |
| tx_en | input | 1 | Transmitter enable |
| tx_fifo_clr | input | 1 | Empties the transmit FIFO |
| tx_wr | input | 1 | Write strobe for the transmit FIFO |
| tx_data | input | 8 | Byte to queue |
| tx_full | output | 1 | Transmit FIFO holds 16 bytes |
| tx_end | output | 1 | All queued bytes fully sent |
| txd | output | 1 | Serial output |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Pop strobe for the receive FIFO |
| rx_data | output | 8 | Last popped byte |
| rx_ferr | output | 1 | Framing error of the last popped byte |
| rx_empty | output | 1 | Receive FIFO holds nothing |

## Verification
The hardest case to reach is a transmitter switched off partway through a frame, because the abandoned frame and the byte still queued behind it must be told apart at the ports. The bench queues two bytes and switches `tx_en` off several bit times into the first frame. The receiver is disabled during this step, so the half-sent frame cannot reach the receive FIFO. The bench then checks that the line holds mark and `tx_end` stays low. It re-enables both directions and expects exactly the second byte to arrive. Short start glitches and frames with a low stop bit are driven onto the line by hand, away from the loopback path, so that start validation and framing-error capture are each tested alone.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_FETCH,
    TX_SHIFT
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // ticks per bit for the selected oversampling ratio
  function automatic logic [4:0] os_len(input logic os8);
    return os8 ? 5'd8 : 5'd16;
  endfunction

  // tick count at which a bit centre is reached
  function automatic logic [4:0] os_mid(input logic os8);
    return os8 ? 5'd4 : 5'd8;
  endfunction

endpackage

// File: rtl/sfx_fifo.sv
module sfx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic         do_push, do_pop;

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (do_pop) begin
      rdata <= mem[rd_ptr[AW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/sfx_tick_gen.sv
module sfx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ck_sel,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             sck_i,
  output logic             tick,
  output logic             sck_o,
  output logic             sck_oe
);

  logic [DIV_W-1:0] cnt;
  logic [2:0]       sck_sync;
  logic             brg_hit, ext_hit, drive_pin;

  assign brg_hit   = (cnt >= baud_div);
  assign ext_hit   = sck_sync[1] && !sck_sync[2];
  assign drive_pin = (ck_sel == 2'b01);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (brg_hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sync <= '0;
    end else begin
      sck_sync <= {sck_sync[1:0], sck_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick   <= 1'b0;
      sck_o  <= 1'b0;
      sck_oe <= 1'b0;
    end else begin
      tick   <= ck_sel[1] ? ext_hit : brg_hit;
      sck_oe <= drive_pin;
      sck_o  <= drive_pin && (cnt <= (baud_div >> 1));
    end
  end

endmodule

// File: rtl/sfx_tx.sv
module sfx_tx
  import sfx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FW    = DATA_W + 2,
  localparam int BCW   = $clog2(FW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              tick,
  input  logic              os8,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              txd,
  output logic              tx_end
);

  tx_state_e      state;
  logic [FW-1:0]  shreg;
  logic [4:0]     os_cnt;
  logic [BCW-1:0] bit_cnt;
  logic           bit_done;

  assign fifo_pop = tx_en && (state == TX_IDLE) && !fifo_empty;
  assign bit_done = tick && ((os_cnt + 5'd1) == os_len(os8));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      shreg   <= '1;
      os_cnt  <= '0;
      bit_cnt <= '0;
      txd     <= 1'b1;
      tx_end  <= 1'b1;
    end else begin
      tx_end <= (state == TX_IDLE) && fifo_empty;
      if (!tx_en) begin
        state   <= TX_IDLE;
        shreg   <= '1;
        os_cnt  <= '0;
        bit_cnt <= '0;
        txd     <= 1'b1;
      end else begin
        case (state)
          TX_IDLE: begin
            if (fifo_pop) state <= TX_FETCH;
          end
          TX_FETCH: begin
            shreg   <= {1'b1, fifo_data, 1'b0};
            os_cnt  <= '0;
            bit_cnt <= '0;
            txd     <= 1'b0;
            state   <= TX_SHIFT;
          end
          TX_SHIFT: begin
            if (bit_done) begin
              os_cnt <= '0;
              if (bit_cnt == BCW'(FW - 1)) begin
                state <= TX_IDLE;
                txd   <= 1'b1;
              end else begin
                shreg   <= {1'b1, shreg[FW-1:1]};
                txd     <= shreg[1];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end else if (tick) begin
              os_cnt <= os_cnt + 5'd1;
            end
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sfx_rx.sv
module sfx_rx
  import sfx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BCW   = $clog2(DATA_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_en,
  input  logic            tick,
  input  logic            os8,
  input  logic            rxd,
  output logic            push,
  output logic [DATA_W:0] pdata
);

  rx_state_e         state;
  logic [2:0]        rx_sync;
  logic [DATA_W-1:0] shreg;
  logic [4:0]        os_cnt;
  logic [BCW-1:0]    bit_cnt;
  logic              line, fell, at_mid, at_end;

  assign line   = rx_sync[1];
  assign fell   = rx_sync[2] && !rx_sync[1];
  assign at_mid = tick && ((os_cnt + 5'd1) == os_mid(os8));
  assign at_end = tick && ((os_cnt + 5'd1) == os_len(os8));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sync <= '1;
    end else begin
      rx_sync <= {rx_sync[1:0], rxd};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      state   <= RX_IDLE;
      shreg   <= '0;
      os_cnt  <= '0;
      bit_cnt <= '0;
      push    <= 1'b0;
      pdata   <= '0;
    end else begin
      push <= 1'b0;
      case (state)
        RX_IDLE: begin
          os_cnt <= '0;
          if (fell) state <= RX_START;
        end
        RX_START: begin
          if (at_mid) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
            state   <= line ? RX_IDLE : RX_DATA;
          end else if (tick) begin
            os_cnt <= os_cnt + 5'd1;
          end
        end
        RX_DATA: begin
          if (at_end) begin
            os_cnt <= '0;
            shreg  <= {line, shreg[DATA_W-1:1]};
            if (bit_cnt == BCW'(DATA_W - 1)) begin
              state <= RX_STOP;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end else if (tick) begin
            os_cnt <= os_cnt + 5'd1;
          end
        end
        RX_STOP: begin
          if (at_end) begin
            os_cnt <= '0;
            push   <= 1'b1;
            pdata  <= {!line, shreg};
            state  <= RX_IDLE;
          end else if (tick) begin
            os_cnt <= os_cnt + 5'd1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_fifo_xcvr.sv
module serial_fifo_xcvr #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ck_sel,
  input  logic              os8,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              tx_en,
  input  logic              tx_fifo_clr,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  output logic              tx_end,
  output logic              txd,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ferr,
  output logic              rx_empty
);

  logic              tick;
  logic              txf_empty, txf_pop;
  logic [DATA_W-1:0] txf_data;
  logic              rx_push, rxf_full, rxf_push;
  logic [DATA_W:0]   rx_word, rxf_out;

  sfx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .ck_sel   (ck_sel),
    .baud_div (baud_div),
    .sck_i    (sck_i),
    .tick     (tick),
    .sck_o    (sck_o),
    .sck_oe   (sck_oe)
  );

  sfx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk   (clk),
    .rst   (rst),
    .clr   (tx_fifo_clr),
    .push  (tx_wr),
    .wdata (tx_data),
    .pop   (txf_pop),
    .rdata (txf_data),
    .empty (txf_empty),
    .full  (tx_full)
  );

  sfx_tx #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .tick       (tick),
    .os8        (os8),
    .fifo_empty (txf_empty),
    .fifo_data  (txf_data),
    .fifo_pop   (txf_pop),
    .txd        (txd),
    .tx_end     (tx_end)
  );

  sfx_rx #(.DATA_W(DATA_W)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .rx_en (rx_en),
    .tick  (tick),
    .os8   (os8),
    .rxd   (rxd),
    .push  (rx_push),
    .pdata (rx_word)
  );

  // a byte finishing just as the receiver is switched off is not stored
  assign rxf_push = rx_push && rx_en && !rxf_full;

  sfx_fifo #(.W(DATA_W + 1), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk   (clk),
    .rst   (rst),
    .clr   (1'b0),
    .push  (rxf_push),
    .wdata (rx_word),
    .pop   (rx_rd),
    .rdata (rxf_out),
    .empty (rx_empty),
    .full  (rxf_full)
  );

  assign rx_data = rxf_out[DATA_W-1:0];
  assign rx_ferr = rxf_out[DATA_W];

endmodule

// File: rtl/sfx_checker.sv
module sfx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        ck_sel,
  input logic              sck_oe,
  input logic              tx_en,
  input logic              tx_fifo_clr,
  input logic              tx_full,
  input logic              tx_end,
  input logic              txd,
  input logic              rx_en,
  input logic              rx_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ferr,
  input logic              rx_empty
);

  // R6: a disabled transmitter holds mark from the next cycle
  a_r6_mark_when_off: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> txd);

  // R4: pin driven only for the internal source with output selected
  a_r4_oe_internal_only: assert property (@(posedge clk) disable iff (rst)
    sck_oe |-> ($past(ck_sel) == 2'b01));

  // R8: nothing left to send implies the line rests at mark
  a_r8_end_means_mark: assert property (@(posedge clk) disable iff (rst)
    tx_end |-> txd);

  // R7: clearing the transmit FIFO leaves it not full
  a_r7_clr_not_full: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_clr |=> !tx_full);

  // R5: a full FIFO with the transmitter off stays full
  a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
    (tx_full && !tx_en && !tx_fifo_clr) |=> tx_full);

  // R11: popping an empty receive FIFO keeps the output word
  a_r11_empty_pop_holds: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && rx_empty) |=> ($stable(rx_data) && $stable(rx_ferr)));

  // R12: a disabled receiver stores nothing
  a_r12_rx_off_no_store: assert property (@(posedge clk) disable iff (rst)
    (rx_empty && !rx_en) |=> rx_empty);

endmodule

bind serial_fifo_xcvr sfx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ck_sel      (ck_sel),
  .sck_oe      (sck_oe),
  .tx_en       (tx_en),
  .tx_fifo_clr (tx_fifo_clr),
  .tx_full     (tx_full),
  .tx_end      (tx_end),
  .txd         (txd),
  .rx_en       (rx_en),
  .rx_rd       (rx_rd),
  .rx_data     (rx_data),
  .rx_ferr     (rx_ferr),
  .rx_empty    (rx_empty)
);

// File: tb/sim_serial_fifo_xcvr.sv
module sim_serial_fifo_xcvr;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ck_sel = 2'b00;
  logic        os8 = 1'b0;
  logic [15:0] baud_div = 16'd3;
  logic        sck_i = 1'b0;
  logic        sck_o, sck_oe;
  logic        tx_en = 1'b0, tx_fifo_clr = 1'b0, tx_wr = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_full, tx_end, txd;
  logic        rx_en = 1'b0, rx_rd = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_ferr, rx_empty;
  logic        loop_sel = 1'b1, rxd_man = 1'b1;
  logic        rxd;

  int  checks = 0, errors = 0;
  int  bit_clks = 64;
  bit  dec_on = 1'b1, mon_on = 1'b1, ext_run = 1'b0, done = 1'b0;
  logic [7:0] txq[$];
  logic [8:0] rxq[$];

  assign rxd = loop_sel ? txd : rxd_man;

  always #10 clk = ~clk;

  serial_fifo_xcvr u0 (
    .clk(clk), .rst(rst), .ck_sel(ck_sel), .os8(os8), .baud_div(baud_div),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .tx_en(tx_en), .tx_fifo_clr(tx_fifo_clr), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .tx_end(tx_end), .txd(txd),
    .rx_en(rx_en), .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .rx_empty(rx_empty)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: queue a byte, optionally expecting it on the line and in the receiver
  task automatic send(input logic [7:0] b, input bit exp_line, input bit exp_rx);
    tx_data = b;
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr   = 1'b0;
    if (exp_line) txq.push_back(b);
    if (exp_rx)   rxq.push_back({1'b0, b});
  endtask

  task automatic wait_idle();
    while (!(tx_end && txq.size() == 0 && rxq.size() == 0)) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic stop);
    rxd_man = 1'b0;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_man = b[i];
      repeat (bit_clks) @(negedge clk);
    end
    rxd_man = stop;
    repeat (bit_clks) @(negedge clk);
    rxd_man = 1'b1;
    repeat (bit_clks) @(negedge clk);
  endtask

  // external oversampling clock: period of 6 system clocks
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (ext_run) sck_i = ~sck_i;
    end
  end

  // line decoder: samples txd at bit centres (R1, R2, R3)
  initial begin
    forever begin
      logic [7:0] got;
      @(negedge txd);
      if (dec_on) begin
        repeat (bit_clks / 2) @(negedge clk);
        check(txd == 1'b0, "R1 start bit low", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_clks) @(negedge clk);
          got[i] = txd;
        end
        repeat (bit_clks) @(negedge clk);
        check(txd == 1'b1, "R1 stop bit high", txd, 1);
        if (txq.size() == 0) begin
          check(1'b0, "R5 R7 unexpected frame on line", got, 0);
        end else begin
          logic [7:0] exp;
          exp = txq.pop_front();
          check(got == exp, "R2 R3 line byte at bit timing", got, exp);
        end
      end
    end
  end

  // monitor: pops the receive FIFO and compares with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && !rx_empty) begin
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        if (rxq.size() == 0) begin
          check(1'b0, "R12 unexpected received byte", {rx_ferr, rx_data}, 0);
        end else begin
          logic [8:0] exp;
          exp = rxq.pop_front();
          check({rx_ferr, rx_data} == exp, "R1 R10 received word", {rx_ferr, rx_data}, exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R1 reset line mark", txd, 1);
    check(tx_end == 1'b1, "R8 reset tx_end", tx_end, 1);
    check(rx_empty == 1'b1, "R11 reset rx_empty", rx_empty, 1);
    check(sck_oe == 1'b0, "R4 reset sck_oe", sck_oe, 0);
    check(tx_full == 1'b0, "R5 reset tx_full", tx_full, 0);

    // 16x internal loopback
    rx_en = 1'b1;
    tx_en = 1'b1;
    send(8'hA5, 1, 1);
    @(negedge clk);
    check(tx_end == 1'b0, "R8 tx_end drops on write", tx_end, 0);
    send(8'h3C, 1, 1);
    send(8'hFF, 1, 1);
    send(8'h00, 1, 1);
    wait_idle();
    check(tx_end == 1'b1, "R8 tx_end after last stop", tx_end, 1);

    // 8x internal loopback
    os8 = 1'b1;
    bit_clks = 32;
    send(8'h5A, 1, 1);
    send(8'h81, 1, 1);
    wait_idle();

    // clock output on the pin
    ck_sel = 2'b01;
    repeat (3) @(negedge clk);
    check(sck_oe == 1'b1, "R4 pin driven for internal+out", sck_oe, 1);
    begin
      int  rises = 0;
      logic prev = sck_o;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sck_o && !prev) rises++;
        prev = sck_o;
      end
      check(rises >= 9 && rises <= 11, "R4 one rise per tick period", rises, 10);
    end
    ck_sel = 2'b00;
    repeat (3) @(negedge clk);
    check(sck_oe == 1'b0 && sck_o == 1'b0, "R4 pin released", {sck_oe, sck_o}, 0);

    // external clock, 8x, 6-cycle source period
    ext_run  = 1'b1;
    baud_div = 16'd200;
    ck_sel   = 2'b10;
    bit_clks = 48;
    repeat (20) @(negedge clk);
    send(8'hC3, 1, 1);
    send(8'h7E, 1, 1);
    wait_idle();
    ck_sel   = 2'b00;
    ext_run  = 1'b0;
    baud_div = 16'd3;
    bit_clks = 32;
    repeat (20) @(negedge clk);

    // full FIFO drops writes
    tx_en = 1'b0;
    for (int i = 0; i < 18; i++) send(8'(i * 7 + 1), i < 16, i < 16);
    check(tx_full == 1'b1, "R5 full after 16 writes", tx_full, 1);
    tx_en = 1'b1;
    wait_idle();
    repeat (400) @(negedge clk);
    check(txq.size() == 0 && rxq.size() == 0, "R5 only 16 bytes sent", txq.size(), 0);

    // disable during a frame
    dec_on = 1'b0;
    rx_en  = 1'b0;
    send(8'h11, 0, 0);
    send(8'h22, 0, 0);
    repeat (100) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R6 mark right after disable", txd, 1);
    begin
      bit held = 1'b1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (!txd) held = 1'b0;
      end
      check(held, "R6 line stays mark while off", held, 1);
    end
    check(tx_end == 1'b0, "R6 queued byte retained", tx_end, 0);
    check(rx_empty == 1'b1, "R12 receiver off stores nothing", rx_empty, 1);
    rx_en  = 1'b1;
    dec_on = 1'b1;
    txq.push_back(8'h22);
    rxq.push_back({1'b0, 8'h22});
    repeat (5) @(negedge clk);
    tx_en = 1'b1;
    wait_idle();

    // FIFO clear
    tx_en = 1'b0;
    send(8'h33, 0, 0);
    send(8'h44, 0, 0);
    @(negedge clk);
    check(tx_end == 1'b0, "R7 bytes queued before clear", tx_end, 0);
    tx_fifo_clr = 1'b1;
    @(negedge clk);
    tx_fifo_clr = 1'b0;
    @(negedge clk);
    check(tx_end == 1'b1, "R7 clear empties FIFO", tx_end, 1);
    tx_en = 1'b1;
    repeat (800) @(negedge clk);
    check(txd == 1'b1 && tx_end == 1'b1, "R7 cleared bytes not sent", {txd, tx_end}, 3);
    check(rx_empty == 1'b1, "R7 nothing received after clear", rx_empty, 1);

    // manual line: start glitch, good frame, framing error
    loop_sel = 1'b0;
    os8      = 1'b0;
    bit_clks = 64;
    repeat (20) @(negedge clk);
    rxd_man = 1'b0;
    repeat (8) @(negedge clk);
    rxd_man = 1'b1;
    repeat (200) @(negedge clk);
    check(rx_empty == 1'b1, "R9 short low pulse ignored", rx_empty, 1);
    rxq.push_back({1'b0, 8'h96});
    drive_frame(8'h96, 1'b1);
    rxq.push_back({1'b1, 8'h69});
    drive_frame(8'h69, 1'b0);
    repeat (40) @(negedge clk);
    check(rxq.size() == 0, "R10 framed bytes delivered", rxq.size(), 0);

    // empty pop keeps last word
    mon_on = 1'b0;
    repeat (5) @(negedge clk);
    check(rx_empty == 1'b1, "R11 drained", rx_empty, 1);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    @(negedge clk);
    check({rx_ferr, rx_data} == 9'h169, "R11 empty pop holds last word",
          {rx_ferr, rx_data}, 9'h169);

    // receiver off ignores a full frame
    rx_en = 1'b0;
    drive_frame(8'h55, 1'b1);
    check(rx_empty == 1'b1, "R12 frame ignored while off", rx_empty, 1);
    rx_en = 1'b1;
    repeat (20) @(negedge clk);
    check(rx_empty == 1'b1, "R12 nothing stored on re-enable", rx_empty, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule